// File: doc/BRIEF.md
# Burst PSRAM WAIT Generator

This block is the memory-side logic that drives the WAIT pin of a burst pseudo-static RAM. It watches the chip-enable, address-valid, output-enable and write-enable strobes. It also takes the burst column at which an access starts, a synchronous-mode enable and a latency-mode bit from the configuration register, and a busy flag from the internal refresh engine. From these it decides, on every clock, whether WAIT is driven and whether it signals "hold". It also produces a one-cycle data-advance strobe for the array's column pointer.

A burst starts on a clock edge where chip enable and address-valid are both low while synchronous mode is on. WAIT then holds for the initial latency, which can differ for reads and writes. In variable-latency mode a read that starts during a refresh is held until the refresh completes. Data then moves one column per clock. When the burst runs past the last column of a row, WAIT holds again while the next row opens. Outside a burst, an asynchronous read drives WAIT asserted and an asynchronous write leaves the pin in high impedance. The block has no data path, so there is no valid/ready handshake. The data-advance strobe acts as a valid-only beat, and the controller applies back-pressure only by deselecting the device.

Top module: `psram_wait_gen`

## Requirements
- R1: While reset is held, and after it is released with chip enable high, `wait_oe` and `adv_strobe` are 0. Reset is asynchronous and active low.
- R2: After the start edge of a synchronous burst, WAIT is driven asserted (`wait_oe`=1, `wait_o`=1 with the default active-high polarity) for exactly RD_LAT cycles on a read (`we_n`=1 at start) or WR_LAT cycles on a write (`we_n`=0 at start). It then deasserts.
- R3: With `lat_fixed`=0, a read that starts while `refresh_busy`=1 keeps WAIT asserted until the first edge at which both the latency has run out and `refresh_busy` is 0. This gives max(RD_LAT, refresh length) cycles. A refresh that begins after the start edge does not stretch the latency.
- R4: With `lat_fixed`=1, the initial latency is RD_LAT or WR_LAT cycles whatever `refresh_busy` does.
- R5: Write bursts are never stretched by refresh, in either latency mode.
- R6: `adv_strobe` is 1 exactly on the burst cycles where WAIT is driven and deasserted. Each pulse moves the internal column up by one, so a burst starting at column C gives 2^COL_W − C consecutive pulses before the row end.
- R7: After the pulse at the last column (all ones), WAIT is asserted for ROW_PEN cycles and the column wraps to 0. Pulses then resume.
- R8: With chip enable low, no burst running or starting, `we_n`=1 and `oe_n`=0, WAIT is driven asserted from the next cycle on.
- R9: With chip enable low, no burst running or starting, and `we_n`=0, `wait_oe` is 0 from the next cycle on.
- R10: A clock edge with `ce_n`=1 returns the block to idle. In the following cycle `wait_oe`=0 and `adv_strobe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address valid, active low; starts a burst in synchronous mode |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; sampled at burst start for direction |
| sync_mode | input | 1 | 1 = synchronous burst accesses enabled |
| lat_fixed | input | 1 | Latency-mode bit: 1 fixed, 0 variable |
| start_col | input | COL_W | Column of the latched start address |
| refresh_busy | input | 1 | Internal refresh in progress |
| wait_o | output | 1 | WAIT level (ACT_HIGH polarity); inactive level when not driven |
| wait_oe | output | 1 | WAIT pad drive enable; 0 = high impedance |
| adv_strobe | output | 1 | Data-advance pulse for the internal column pointer |

## Verification
On every cycle, the embedded properties check three things: the tri-state release after deselect or an asynchronous write, the asserted WAIT of asynchronous reads, and that fixed latency ends as soon as the counter expires. They also check that every rise of the data-advance strobe follows a held WAIT cycle, and that a pulse at the last column is followed by a row-open hold and a column wrap. The bench scenarios measure the exact cycle counts the properties cannot see. These are the latency per direction, the stretched and unstretched lengths for refreshes of different lengths and timing, the number of data beats before the row end for several start columns, and the row-open penalty length.

// File: rtl/pwg_pkg.sv
package pwg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LAT  = 3'd1,
    ST_DATA = 3'd2,
    ST_ROW  = 3'd3,
    ST_ARD  = 3'd4,
    ST_AWR  = 3'd5
  } pwg_state_e;

  function automatic bit is_burst(input pwg_state_e s);
    return (s == ST_LAT) || (s == ST_DATA) || (s == ST_ROW);
  endfunction

endpackage

// File: rtl/pwg_cnt.sv
module pwg_cnt #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (load)               cnt_q <= load_val;
    else if (dec && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && zero) |=> zero); // R2

endmodule

// File: rtl/pwg_col.sv
module pwg_col #(
  parameter int COL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [COL_W-1:0] load_col,
  input  logic             step,
  output logic             col_last
);

  logic [COL_W-1:0] col_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    col_q <= '0;
    else if (load) col_q <= load_col;
    else if (step) col_q <= col_q + 1'b1;
  end

  assign col_last = &col_q;

  AST_COL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && col_last) |=> (col_q == '0)); // R7

endmodule

// File: rtl/pwg_pad.sv
module pwg_pad
  import pwg_pkg::*;
#(
  parameter bit ACT_HIGH = 1'b1
) (
  input  pwg_state_e st,
  output logic       wait_o,
  output logic       wait_oe,
  output logic       adv_strobe
);

  logic hold;

  always_comb begin
    hold       = (st == ST_LAT) || (st == ST_ROW) || (st == ST_ARD);
    wait_oe    = is_burst(st) || (st == ST_ARD);
    adv_strobe = (st == ST_DATA);
    wait_o     = (wait_oe && hold) ? ACT_HIGH : ~ACT_HIGH;
  end

endmodule

// File: rtl/psram_wait_gen.sv
module psram_wait_gen
  import pwg_pkg::*;
#(
  parameter int COL_W    = 4,
  parameter int RD_LAT   = 3,
  parameter int WR_LAT   = 2,
  parameter int ROW_PEN  = 2,
  parameter bit ACT_HIGH = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             adv_n,
  input  logic             oe_n,
  input  logic             we_n,
  input  logic             sync_mode,
  input  logic             lat_fixed,
  input  logic [COL_W-1:0] start_col,
  input  logic             refresh_busy,
  output logic             wait_o,
  output logic             wait_oe,
  output logic             adv_strobe
);

  localparam int MAX_AB = (RD_LAT > WR_LAT) ? RD_LAT : WR_LAT;
  localparam int MAX_C  = (MAX_AB > ROW_PEN) ? MAX_AB : ROW_PEN;
  localparam int CW     = $clog2(MAX_C + 1);
  localparam logic [CW-1:0] RD_LOAD  = CW'(RD_LAT - 1);
  localparam logic [CW-1:0] WR_LOAD  = CW'(WR_LAT - 1);
  localparam logic [CW-1:0] ROW_LOAD = CW'(ROW_PEN - 1);

  pwg_state_e st_q, st_d;
  logic       coll_q, fixed_q;
  logic       start, cnt_zero, cnt_load, col_last;
  logic [CW-1:0] cnt_val;

  assign start = !ce_n && !adv_n && sync_mode;

  always_comb begin
    st_d     = st_q;
    cnt_load = 1'b0;
    cnt_val  = ROW_LOAD;
    if (ce_n) begin
      st_d = ST_IDLE;
    end else if (start) begin
      st_d     = ST_LAT;
      cnt_load = 1'b1;
      cnt_val  = we_n ? RD_LOAD : WR_LOAD;
    end else begin
      case (st_q)
        ST_LAT:  if (cnt_zero && !(coll_q && refresh_busy)) st_d = ST_DATA;
        ST_DATA: if (col_last) begin
                   st_d     = ST_ROW;
                   cnt_load = 1'b1;
                 end
        ST_ROW:  if (cnt_zero) st_d = ST_DATA;
        default: begin
          if (!we_n)      st_d = ST_AWR;
          else if (!oe_n) st_d = ST_ARD;
          else            st_d = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      coll_q  <= 1'b0;
      fixed_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (start) begin
        coll_q  <= !lat_fixed && refresh_busy && we_n;
        fixed_q <= lat_fixed;
      end
    end
  end

  pwg_cnt #(.W(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .dec      ((st_q == ST_LAT) || (st_q == ST_ROW)),
    .zero     (cnt_zero)
  );

  pwg_col #(.COL_W(COL_W)) u_col (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .load_col (start_col),
    .step     (st_q == ST_DATA),
    .col_last (col_last)
  );

  pwg_pad #(.ACT_HIGH(ACT_HIGH)) u_pad (
    .st         (st_q),
    .wait_o     (wait_o),
    .wait_oe    (wait_oe),
    .adv_strobe (adv_strobe)
  );

  AST_HIZ_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> (!wait_oe && !adv_strobe)); // R10

  AST_ASYNC_WR_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !start && !we_n && !is_burst(st_q)) |=> !wait_oe); // R9

  AST_ASYNC_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !start && we_n && !oe_n && !is_burst(st_q))
      |=> (wait_oe && wait_o == ACT_HIGH)); // R8

  AST_FIXED_NO_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LAT && cnt_zero && fixed_q && !ce_n && !start) |=> adv_strobe); // R4

  AST_STROBE_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adv_strobe) |-> $past(wait_oe && wait_o == ACT_HIGH)); // R6

  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_strobe && col_last && !ce_n && !start)
      |=> (wait_oe && wait_o == ACT_HIGH)); // R7

endmodule

// File: tb/psram_wait_gen_tb_top.sv
`timescale 1ns/1ps
module psram_wait_gen_tb_top;

  localparam int COL_W = 4, RD_LAT = 3, WR_LAT = 2, ROW_PEN = 2;
  localparam int NCOL = 1 << COL_W;
  localparam int NV = 8;
  // columns: write, fixed, refresh length, start column, expected latency, req code
  localparam int VEC [NV][6] = '{
    '{0, 0, 0, 0,  3, 2},
    '{1, 0, 0, 5,  2, 2},
    '{0, 0, 5, 10, 5, 3},
    '{0, 1, 5, 3,  3, 4},
    '{1, 0, 5, 15, 2, 5},
    '{0, 0, 2, 14, 3, 3},
    '{1, 1, 4, 8,  2, 4},
    '{0, 0, 7, 1,  7, 3}
  };

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, adv_n = 1, oe_n = 1, we_n = 1, sync_mode = 1, lat_fixed = 0;
  logic [COL_W-1:0] start_col = '0;
  logic refresh_busy = 0;
  logic wait_o, wait_oe, adv_strobe;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  psram_wait_gen #(.COL_W(COL_W), .RD_LAT(RD_LAT), .WR_LAT(WR_LAT),
                   .ROW_PEN(ROW_PEN), .ACT_HIGH(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n), .oe_n(oe_n),
    .we_n(we_n), .sync_mode(sync_mode), .lat_fixed(lat_fixed),
    .start_col(start_col), .refresh_busy(refresh_busy),
    .wait_o(wait_o), .wait_oe(wait_oe), .adv_strobe(adv_strobe));

  function automatic bit wait_on();
    return wait_oe && wait_o;
  endfunction

  function automatic string tag(input int code);
    case (code)
      2: return "R2";
      3: return "R3";
      4: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Starts a burst; refresh stays high for rf edges from the start edge on.
  task automatic start_burst(input bit wr, input bit fx, input int rf, input int col);
    @(negedge clk);
    ce_n = 0; adv_n = 0; sync_mode = 1; we_n = !wr; oe_n = wr;
    lat_fixed = fx; start_col = COL_W'(col); refresh_busy = (rf > 0);
  endtask

  task automatic measure_latency(input int rf, output int wc);
    bit done = 0;
    wc = 0;
    for (int k = 1; k < 60 && !done; k++) begin
      @(negedge clk);
      adv_n = 1;
      if (wait_on()) wc++; else done = 1;
      refresh_busy = (k < rf);
    end
    refresh_busy = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int wc, sc, rc;
    bit done;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!wait_oe, "R1", wait_oe, 0);
    chk(!adv_strobe, "R1", adv_strobe, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!wait_oe && !adv_strobe, "R1", {wait_oe, adv_strobe}, 0);

    for (int i = 0; i < NV; i++) begin
      start_burst(VEC[i][0] != 0, VEC[i][1] != 0, VEC[i][2], VEC[i][3]);
      measure_latency(VEC[i][2], wc);
      chk(wc == VEC[i][4], tag(VEC[i][5]), wc, VEC[i][4]);
      // R6: data beats up to the row end
      sc = adv_strobe ? 1 : 0;
      done = 0;
      for (int k = 0; k < 40 && !done; k++) begin
        @(negedge clk);
        if (adv_strobe && !wait_on()) sc++; else done = 1;
      end
      chk(sc == NCOL - VEC[i][3], "R6", sc, NCOL - VEC[i][3]);
      // R7: row-open hold
      rc = wait_on() ? 1 : 0;
      done = 0;
      for (int k = 0; k < 20 && !done; k++) begin
        @(negedge clk);
        if (wait_on()) rc++; else done = 1;
      end
      chk(rc == ROW_PEN, "R7", rc, ROW_PEN);
      chk(adv_strobe == 1, "R7", adv_strobe, 1);
      // R10: deselect
      ce_n = 1;
      @(negedge clk);
      chk(!wait_oe && !adv_strobe, "R10", {wait_oe, adv_strobe}, 0);
    end

    // R3: refresh that begins after the start edge does not stretch
    start_burst(1'b0, 1'b0, 0, 4);
    @(negedge clk);
    adv_n = 1; refresh_busy = 1;
    wc = wait_on() ? 1 : 0;
    done = 0;
    for (int k = 0; k < 20 && !done; k++) begin
      @(negedge clk);
      if (wait_on()) wc++; else done = 1;
    end
    refresh_busy = 0;
    chk(wc == RD_LAT, "R3", wc, RD_LAT);
    ce_n = 1;
    @(negedge clk);

    // R10: deselect during initial latency
    start_burst(1'b0, 1'b1, 0, 0);
    @(negedge clk);
    adv_n = 1; ce_n = 1;
    @(negedge clk);
    chk(!wait_oe && !adv_strobe, "R10", {wait_oe, adv_strobe}, 0);

    // R8: asynchronous read
    sync_mode = 0; ce_n = 0; adv_n = 1; we_n = 1; oe_n = 0;
    @(negedge clk);
    chk(wait_on(), "R8", {wait_oe, wait_o}, 3);
    // R9: asynchronous write
    we_n = 0; oe_n = 1;
    @(negedge clk);
    chk(!wait_oe, "R9", wait_oe, 0);
    // R9: write with synchronous mode on but no address-valid
    sync_mode = 1;
    @(negedge clk);
    chk(!wait_oe, "R9", wait_oe, 0);
    ce_n = 1; we_n = 1;
    @(negedge clk);

    // R1: reset in the middle of a burst
    start_burst(1'b0, 1'b0, 0, 0);
    @(negedge clk);
    adv_n = 1; rst_n = 0;
    #1;
    chk(!wait_oe && !adv_strobe, "R1", {wait_oe, adv_strobe}, 0);
    @(negedge clk);
    ce_n = 1; rst_n = 1;
    @(negedge clk);

    finish_run();
  end

endmodule